// File: doc/BRIEF.md
# Outbound Split Read Tracker

This block takes read requests from a local processor bus and sends them toward an external PCI-style bus. A request is never held on the local bus while the data is fetched. The block accepts the request into a transaction queue and at once sends back a split-response pulse carrying the requester's tag. Later it delivers the fetched data as a completion stream that carries the same tag. Memory reads and I/O reads go through the same queue; the command bit is passed unchanged to the bus side.

Returning data is staged in a read buffer of four segments. A 2-bit maximum-read-byte-count setting sets the size of each segment. The smallest setting (512 bytes, the reset default) gives 2 KB of usable buffer. Any larger setting gives 1024-byte segments and 4 KB in total. A request longer than one segment is cut into consecutive segment-sized bus reads. A bus read is issued only when a segment is free, so returning data always has a place to land.

The bus side must return the data for its reads in the order the reads were issued. It returns one 32-bit beat per valid cycle. After a beat flagged as an error it sends no further beats for that read. Request lengths are non-zero multiples of 4 bytes and at most 4096.

Top module: `split_read_tracker`

## Requirements
- R1: `req_ready` is low while 8 requests are waiting in the transaction queue; a request offered then is neither accepted nor answered.
- R2: Each accepted request (`req_valid` and `req_ready` high at a clock edge) produces exactly one `split_rsp` pulse in the next cycle, with `split_tag` equal to the accepted `req_tag`.
- R3: Every bus read carries the command bit of its request (`bus_io` 0 = memory read, 1 = I/O read), and a bus read that is not yet accepted keeps its address.
- R4: With `rbc_code` = 0 (512 bytes), each segment holds 512 bytes. A request is issued as bus reads of at most 512 bytes at consecutive addresses. The last read carries the remainder.
- R5: With `rbc_code` = 1, 2 or 3 (1024, 2048, 4096 bytes), each segment holds 1024 bytes. Requests are cut into bus reads of at most 1024 bytes.
- R6: At most 4 bus reads are outstanding (issued but not yet fully delivered on the completion stream). Further reads wait for a segment to free.
- R7: A successful bus read of N bytes yields N/4 completion beats carrying the bus data in arrival order. `cpl_last` is high only on the final beat of the whole request.
- R8: Completions are delivered in request order, each beat tagged with its request's tag.
- R9: A bus read that ends with `bus_rd_err` yields a single completion beat with `cpl_err` = 1 and `cpl_data` = 0 instead of its data. Its segment is then freed for later reads.
- R10: During and right after reset `req_ready` is 1 and `split_rsp`, `cpl_valid` and `bus_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rbc_code | input | 2 | Maximum read byte count code (0=512, 1=1024, 2=2048, 3=4096) |
| req_valid | input | 1 | Local read request present |
| req_ready | output | 1 | Transaction queue has room |
| req_addr | input | 32 | Request start address |
| req_io | input | 1 | 0 = memory read, 1 = I/O read |
| req_len | input | 13 | Request length in bytes |
| req_tag | input | 4 | Requester tag |
| split_rsp | output | 1 | Split-response termination pulse |
| split_tag | output | 4 | Tag of the request just split |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_data | output | 32 | Completion data |
| cpl_tag | output | 4 | Requester tag of the beat |
| cpl_err | output | 1 | Error completion beat |
| cpl_last | output | 1 | Final beat of the request |
| bus_req_valid | output | 1 | Bus read request present |
| bus_req_ready | input | 1 | Bus side takes the read |
| bus_addr | output | 32 | Bus read address |
| bus_io | output | 1 | Bus read command (0 memory, 1 I/O) |
| bus_len | output | 13 | Bus read length in bytes |
| bus_rd_valid | input | 1 | Returning data beat valid |
| bus_rd_data | input | 32 | Returning data beat |
| bus_rd_err | input | 1 | Returning beat ends the read with an error |

## Verification
The main function is tried with short single-segment memory reads, a one-beat I/O read, and lengths of 600, 1024 and 2048 bytes under different read-byte-count codes. These show whether splitting follows the segment size and whether the remainder is carried correctly. A backlog of eight queued requests behind a stalled bus separates the queue-full refusal from the split-response path. Six requests whose data is held back show whether issue stops at four segments. Errors on a one-segment read and on the second half of a split read show that the error beat replaces only that read's data and that the segment is freed for a later request.

// File: rtl/srt_pkg.sv
// Shared widths, codes and request record for the outbound split read tracker.
package srt_pkg;
    localparam int ADDR_W     = 32;
    localparam int TAG_W      = 4;
    localparam int LEN_W      = 13;
    localparam int DATA_W     = 32;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int SEG_SMALL  = 512;
    localparam int SEG_LARGE  = 1024;
    localparam int SEG_WORDS  = SEG_LARGE / BEAT_BYTES;
    localparam int BEATS_W    = $clog2(SEG_WORDS) + 1;

    typedef enum logic [1:0] {
        RBC_512 = 2'd0,
        RBC_1K  = 2'd1,
        RBC_2K  = 2'd2,
        RBC_4K  = 2'd3
    } rbc_code_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              io;
        logic [LEN_W-1:0]  len;
        logic [TAG_W-1:0]  tag;
    } rd_req_t;

    // Segment size in bytes selected by the read byte count code.
    function automatic logic [LEN_W-1:0] seg_bytes(rbc_code_e code);
        return (code == RBC_512) ? LEN_W'(SEG_SMALL) : LEN_W'(SEG_LARGE);
    endfunction
endpackage

// File: rtl/srt_req_fifo.sv
// Transaction queue: holds accepted read requests in arrival order.
// Assumes push is only asserted while not full and pop only while not empty.
module srt_req_fifo
    import srt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  rd_req_t din,
    input  logic    pop,
    output rd_req_t dout,
    output logic    full,
    output logic    empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rd_req_t          slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign dout  = slots[rd_ptr];

    // Store the incoming request in its slot.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            slots[wr_ptr] <= din;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr <= step(wr_ptr);
            end
            if (pop && !empty) begin
                rd_ptr <= step(rd_ptr);
            end
            count <= count + CNT_W'(push && !full) - CNT_W'(pop && !empty);
        end
    end
endmodule

// File: rtl/srt_issuer.sv
// Bus read issuer: cuts the head request into segment-sized bus reads and
// allocates one buffer segment per read. Issues only while a segment is free.
module srt_issuer
    import srt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  rd_req_t            head,
    input  logic               head_valid,
    input  rbc_code_e          rbc,
    input  logic               seg_free,
    output logic               pop,
    output logic               bus_req_valid,
    input  logic               bus_req_ready,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_io,
    output logic [LEN_W-1:0]   bus_len,
    output logic               alloc,
    output logic [TAG_W-1:0]   alloc_tag,
    output logic [BEATS_W-1:0] alloc_beats,
    output logic               alloc_last
);
    logic [LEN_W-1:0] offset;
    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] seg;
    logic [LEN_W-1:0] chunk;
    logic             final_piece;

    // Size the next piece of the head request.
    always_comb begin
        seg         = seg_bytes(rbc);
        remain      = head.len - offset;
        final_piece = (remain <= seg);
        chunk       = final_piece ? remain : seg;
    end

    assign bus_req_valid = head_valid && seg_free;
    assign bus_addr      = head.addr + ADDR_W'(offset);
    assign bus_io        = head.io;
    assign bus_len       = chunk;
    assign alloc         = bus_req_valid && bus_req_ready;
    assign alloc_tag     = head.tag;
    assign alloc_beats   = BEATS_W'(chunk / LEN_W'(BEAT_BYTES));
    assign alloc_last    = final_piece;
    assign pop           = alloc && final_piece;

    // Track how far into the head request issue has progressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (alloc) begin
            offset <= final_piece ? '0 : offset + chunk;
        end
    end
endmodule

// File: rtl/srt_seg_buffer.sv
// Read data buffer: NSEG segments used as a ring in issue order. Each segment
// fills from the bus (data assumed to return in issue order) and, once
// complete, drains one beat per cycle onto the completion stream.
// Assumes NSEG is a power of two and the bus never returns unrequested data.
module srt_seg_buffer
    import srt_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic [BEATS_W-1:0]           alloc_beats,
    input  logic                         alloc_last,
    output logic                         seg_free,
    output logic [$clog2(NSEG+1)-1:0]    seg_used,
    input  logic                         bus_rd_valid,
    input  logic [DATA_W-1:0]            bus_rd_data,
    input  logic                         bus_rd_err,
    output logic                         cpl_valid,
    output logic [DATA_W-1:0]            cpl_data,
    output logic [TAG_W-1:0]             cpl_tag,
    output logic                         cpl_err,
    output logic                         cpl_last
);
    localparam int IDX_W  = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int WIDX_W = $clog2(SEG_WORDS);
    localparam int USED_W = $clog2(NSEG + 1);
    localparam int MEM_W  = NSEG * SEG_WORDS;

    logic [DATA_W-1:0]  mem [MEM_W];
    logic [TAG_W-1:0]   rec_tag   [NSEG];
    logic [BEATS_W-1:0] rec_beats [NSEG];
    logic [NSEG-1:0]    rec_last;
    logic [NSEG-1:0]    rec_done;
    logic [NSEG-1:0]    rec_err;

    logic [IDX_W-1:0]   alloc_ptr, fill_ptr, drain_ptr;
    logic [BEATS_W-1:0] fill_idx, drain_idx;
    logic               fill_end, drain_go, drain_end;
    logic [DATA_W-1:0]  rd_word;

    // Decide fill completion and whether a drain beat goes out this cycle.
    always_comb begin
        fill_end  = bus_rd_valid && (bus_rd_err || (fill_idx + 1'b1 == rec_beats[fill_ptr]));
        drain_go  = (seg_used != '0) && rec_done[drain_ptr];
        drain_end = drain_go && (rec_err[drain_ptr] || (drain_idx + 1'b1 == rec_beats[drain_ptr]));
    end

    assign seg_free = (seg_used < USED_W'(NSEG));
    assign cpl_data = rd_word;

    // Record the tag, size and last flag of a newly issued bus read.
    always_ff @(posedge clk) begin
        if (alloc) begin
            rec_tag[alloc_ptr]   <= alloc_tag;
            rec_beats[alloc_ptr] <= alloc_beats;
            rec_last[alloc_ptr]  <= alloc_last;
        end
    end

    // Write returning data and read the next drain beat.
    always_ff @(posedge clk) begin
        if (bus_rd_valid && !bus_rd_err) begin
            mem[{fill_ptr, fill_idx[WIDX_W-1:0]}] <= bus_rd_data;
        end
        if (drain_go) begin
            rd_word <= rec_err[drain_ptr] ? '0 : mem[{drain_ptr, drain_idx[WIDX_W-1:0]}];
        end
    end

    // Ring pointers, segment state and the registered completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_ptr <= '0;
            fill_ptr  <= '0;
            drain_ptr <= '0;
            fill_idx  <= '0;
            drain_idx <= '0;
            seg_used  <= '0;
            rec_done  <= '0;
            rec_err   <= '0;
            cpl_valid <= 1'b0;
            cpl_tag   <= '0;
            cpl_err   <= 1'b0;
            cpl_last  <= 1'b0;
        end else begin
            if (alloc) begin
                alloc_ptr <= alloc_ptr + 1'b1;
            end
            if (bus_rd_valid) begin
                fill_idx <= fill_end ? '0 : fill_idx + 1'b1;
                if (fill_end) begin
                    rec_done[fill_ptr] <= 1'b1;
                    rec_err[fill_ptr]  <= bus_rd_err;
                    fill_ptr           <= fill_ptr + 1'b1;
                end
            end
            cpl_valid <= drain_go;
            if (drain_go) begin
                cpl_tag   <= rec_tag[drain_ptr];
                cpl_err   <= rec_err[drain_ptr];
                cpl_last  <= drain_end && rec_last[drain_ptr];
                drain_idx <= drain_end ? '0 : drain_idx + 1'b1;
                if (drain_end) begin
                    rec_done[drain_ptr] <= 1'b0;
                    drain_ptr           <= drain_ptr + 1'b1;
                end
            end
            seg_used <= seg_used + USED_W'(alloc) - USED_W'(drain_end);
        end
    end
endmodule

// File: rtl/split_read_tracker.sv
// Outbound split read tracker top: accepts local reads into the transaction
// queue, answers each with a split-response pulse, issues segment-sized bus
// reads and returns the data as a tagged completion stream.
module split_read_tracker
    import srt_pkg::*;
#(
    parameter int Q_DEPTH = 8,
    parameter int NSEG    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rbc_code,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              split_rsp,
    output logic [TAG_W-1:0]  split_tag,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_data,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic              cpl_err,
    output logic              cpl_last,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_io,
    output logic [LEN_W-1:0]  bus_len,
    input  logic              bus_rd_valid,
    input  logic [DATA_W-1:0] bus_rd_data,
    input  logic              bus_rd_err
);
    localparam int USED_W = $clog2(NSEG + 1);

    rd_req_t            new_req, head;
    logic               q_full, q_empty, q_pop, accept;
    logic               seg_free, alloc, alloc_last;
    logic [TAG_W-1:0]   alloc_tag;
    logic [BEATS_W-1:0] alloc_beats;
    logic [USED_W-1:0]  seg_used;

    assign new_req   = '{addr: req_addr, io: req_io, len: req_len, tag: req_tag};
    assign req_ready = !q_full;
    assign accept    = req_valid && req_ready;

    // Split-response pulse for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_rsp <= 1'b0;
            split_tag <= '0;
        end else begin
            split_rsp <= accept;
            if (accept) begin
                split_tag <= req_tag;
            end
        end
    end

    srt_req_fifo #(.DEPTH(Q_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (new_req),
        .pop   (q_pop),
        .dout  (head),
        .full  (q_full),
        .empty (q_empty)
    );

    srt_issuer u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .head          (head),
        .head_valid    (!q_empty),
        .rbc           (rbc_code_e'(rbc_code)),
        .seg_free      (seg_free),
        .pop           (q_pop),
        .bus_req_valid (bus_req_valid),
        .bus_req_ready (bus_req_ready),
        .bus_addr      (bus_addr),
        .bus_io        (bus_io),
        .bus_len       (bus_len),
        .alloc         (alloc),
        .alloc_tag     (alloc_tag),
        .alloc_beats   (alloc_beats),
        .alloc_last    (alloc_last)
    );

    srt_seg_buffer #(.NSEG(NSEG)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc        (alloc),
        .alloc_tag    (alloc_tag),
        .alloc_beats  (alloc_beats),
        .alloc_last   (alloc_last),
        .seg_free     (seg_free),
        .seg_used     (seg_used),
        .bus_rd_valid (bus_rd_valid),
        .bus_rd_data  (bus_rd_data),
        .bus_rd_err   (bus_rd_err),
        .cpl_valid    (cpl_valid),
        .cpl_data     (cpl_data),
        .cpl_tag      (cpl_tag),
        .cpl_err      (cpl_err),
        .cpl_last     (cpl_last)
    );
endmodule

// File: rtl/srt_checker.sv
// Protocol checker for split_read_tracker, attached by bind.
module srt_checker #(
    parameter int NSEG = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [3:0]                req_tag,
    input logic                      split_rsp,
    input logic [3:0]                split_tag,
    input logic [1:0]                rbc_code,
    input logic                      bus_req_valid,
    input logic                      bus_req_ready,
    input logic [31:0]               bus_addr,
    input logic [12:0]               bus_len,
    input logic                      cpl_valid,
    input logic [$clog2(NSEG+1)-1:0] seg_used
);
    // R2
    split_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (split_rsp && split_tag == $past(req_tag)));

    // R2
    split_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_rsp |-> $past(req_valid && req_ready));

    // R3
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_addr)));

    // R4
    small_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && rbc_code == 2'd0) |-> (bus_len <= 13'd512 && bus_len != 13'd0));

    // R5
    large_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_len <= 13'd1024));

    // R6
    seg_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (seg_used < NSEG));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!split_rsp && !cpl_valid));
endmodule

bind split_read_tracker srt_checker #(.NSEG(NSEG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_tag       (req_tag),
    .split_rsp     (split_rsp),
    .split_tag     (split_tag),
    .rbc_code      (rbc_code),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_addr      (bus_addr),
    .bus_len       (bus_len),
    .cpl_valid     (cpl_valid),
    .seg_used      (u_buf.seg_used)
);

// File: tb/split_read_tracker_bench.sv
// Bench: vector table walked by one loop, then directed reset/corner tests.
module split_read_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rbc_code = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic [12:0] req_len = '0;
    logic [3:0]  req_tag = '0;
    logic        split_rsp;
    logic [3:0]  split_tag;
    logic        cpl_valid;
    logic [31:0] cpl_data;
    logic [3:0]  cpl_tag;
    logic        cpl_err;
    logic        cpl_last;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b1;
    logic [31:0] bus_addr;
    logic        bus_io;
    logic [12:0] bus_len;
    logic        bus_rd_valid = 1'b0;
    logic [31:0] bus_rd_data = '0;
    logic        bus_rd_err = 1'b0;

    always #10 clk = ~clk;

    split_read_tracker u_split_read_tracker (.*);

    int total = 0;
    int bad = 0;

    // Expected bus reads and completion beats, computed from the requirements.
    logic [31:0] ei_addr [0:63];
    logic [12:0] ei_len  [0:63];
    logic        ei_io   [0:63];
    logic [1:0]  ei_code [0:63];
    int          ei_n = 0, ei_rd = 0;
    logic [31:0] ec_data [0:4095];
    logic [3:0]  ec_tag  [0:4095];
    logic        ec_err  [0:4095];
    logic        ec_last [0:4095];
    int          ec_n = 0, ec_rd = 0;

    // Bench bus responder state.
    logic [31:0] rs_addr  [0:63];
    int          rs_beats [0:63];
    logic        rs_err   [0:63];
    int          rs_wr = 0, rs_rd = 0, rs_i = 0;
    logic        rs_hold = 1'b0;
    logic [31:0] err_addr = 32'hFFFF_FFFC;

    // Vector: {addr[51:20], io[19], len[18:6], tag[5:2], code[1:0]}
    localparam logic [51:0] VECS [0:6] = '{
        {32'h0000_1000, 1'b0, 13'd16,   4'd1, 2'd0},
        {32'h0000_2000, 1'b1, 13'd4,    4'd2, 2'd0},
        {32'h0000_3000, 1'b0, 13'd1024, 4'd3, 2'd0},
        {32'h0000_4000, 1'b0, 13'd1024, 4'd4, 2'd1},
        {32'h0000_5000, 1'b0, 13'd2048, 4'd5, 2'd3},
        {32'h0000_6000, 1'b0, 13'd600,  4'd6, 2'd0},
        {32'h0000_7000, 1'b0, 13'd12,   4'd7, 2'd2}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expand a request into expected bus reads and completion beats.
    task automatic plan(input logic [31:0] a, input logic io, input int len,
                        input logic [3:0] tag, input logic [1:0] code);
        int seg = (code == 2'd0) ? 512 : 1024;
        int off = 0;
        while (off < len) begin
            int ch = (len - off > seg) ? seg : len - off;
            logic fin = (off + ch == len);
            ei_addr[ei_n] = a + off; ei_len[ei_n] = 13'(ch);
            ei_io[ei_n] = io; ei_code[ei_n] = code; ei_n++;
            if (a + off == err_addr) begin
                ec_data[ec_n] = '0; ec_tag[ec_n] = tag; ec_err[ec_n] = 1'b1;
                ec_last[ec_n] = fin; ec_n++;
            end else begin
                for (int k = 0; k < ch / 4; k++) begin
                    ec_data[ec_n] = a + off + 4 * k; ec_tag[ec_n] = tag;
                    ec_err[ec_n] = 1'b0; ec_last[ec_n] = fin && (k == ch / 4 - 1); ec_n++;
                end
            end
            off += ch;
        end
    endtask

    task automatic send(input logic [31:0] a, input logic io, input logic [12:0] len,
                        input logic [3:0] tag, input logic [1:0] code);
        rbc_code = code;
        plan(a, io, int'(len), tag, code);
        req_addr = a; req_io = io; req_len = len; req_tag = tag; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(split_rsp == 1'b1 && split_tag == tag, "R2 split", {split_rsp, split_tag}, {1'b1, tag});
    endtask

    task automatic wait_drain();
        while (ec_rd < ec_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor and bus responder, just after each falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (!rs_hold && rs_rd != rs_wr) begin
                bus_rd_valid = 1'b1;
                bus_rd_err   = rs_err[rs_rd];
                bus_rd_data  = rs_err[rs_rd] ? 32'h0 : rs_addr[rs_rd] + 4 * rs_i;
                if (rs_err[rs_rd] || rs_i + 1 == rs_beats[rs_rd]) begin
                    rs_rd++; rs_i = 0;
                end else begin
                    rs_i++;
                end
            end else begin
                bus_rd_valid = 1'b0;
                bus_rd_err   = 1'b0;
            end
            if (bus_req_valid && bus_req_ready) begin
                if (ei_rd < ei_n) begin
                    chk(bus_addr == ei_addr[ei_rd] && bus_len == ei_len[ei_rd],
                        (ei_code[ei_rd] == 2'd0) ? "R4 bus read" : "R5 bus read",
                        {bus_addr, bus_len}, {ei_addr[ei_rd], ei_len[ei_rd]});
                    chk(bus_io == ei_io[ei_rd], "R3 command", bus_io, ei_io[ei_rd]);
                end else begin
                    chk(1'b0, "R6 unexpected bus read", bus_addr, 0);
                end
                rs_addr[rs_wr] = bus_addr; rs_beats[rs_wr] = int'(bus_len) / 4;
                rs_err[rs_wr] = (bus_addr == err_addr); rs_wr++;
                ei_rd++;
            end
            if (cpl_valid) begin
                if (ec_rd < ec_n) begin
                    chk(cpl_err == ec_err[ec_rd], "R9 error flag", cpl_err, ec_err[ec_rd]);
                    chk(cpl_data == ec_data[ec_rd], ec_err[ec_rd] ? "R9 data" : "R7 data",
                        cpl_data, ec_data[ec_rd]);
                    chk(cpl_tag == ec_tag[ec_rd], "R8 tag order", cpl_tag, ec_tag[ec_rd]);
                    chk(cpl_last == ec_last[ec_rd], "R7 last", cpl_last, ec_last[ec_rd]);
                end else begin
                    chk(1'b0, "R8 unexpected completion", cpl_data, 0);
                end
                ec_rd++;
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R10: state while in reset
        chk(req_ready == 1'b1 && split_rsp == 1'b0 && cpl_valid == 1'b0 && bus_req_valid == 1'b0,
            "R10 reset", {req_ready, split_rsp, cpl_valid, bus_req_valid}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && split_rsp == 1'b0 && cpl_valid == 1'b0 && bus_req_valid == 1'b0,
            "R10 after reset", {req_ready, split_rsp, cpl_valid, bus_req_valid}, 4'b1000);

        // Table walk: R3, R4, R5, R7
        for (int v = 0; v < 7; v++) begin
            send(VECS[v][51:20], VECS[v][19], VECS[v][18:6], VECS[v][5:2], VECS[v][1:0]);
            wait_drain();
        end

        // R1: queue of 8 behind a stalled bus refuses a ninth request
        bus_req_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            send(32'h0000_B000 + 32'h100 * i, 1'b0, 13'd8, 4'(i + 8), 2'd0);
        end
        chk(req_ready == 1'b0, "R1 full", req_ready, 0);
        req_addr = 32'h0000_C000; req_tag = 4'd15; req_len = 13'd8; req_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(split_rsp == 1'b0 && req_ready == 1'b0, "R1 refused", {split_rsp, req_ready}, 0);
        end
        req_valid = 1'b0;
        bus_req_ready = 1'b1;
        wait_drain();

        // R6: data held back, only four reads issue
        rs_hold = 1'b1;
        base = ei_rd;
        for (int i = 0; i < 6; i++) begin
            send(32'h0000_D000 + 32'h40 * i, 1'b0, 13'd8, 4'(i), 2'd1);
        end
        repeat (10) @(negedge clk);
        chk(ei_rd - base == 4, "R6 outstanding", ei_rd - base, 4);
        rs_hold = 1'b0;
        wait_drain();

        // R9: error on a single read, then on the second piece of a split read
        err_addr = 32'h0000_8000;
        send(32'h0000_8000, 1'b0, 13'd16, 4'd9, 2'd0);
        wait_drain();
        err_addr = 32'h0000_9200;
        send(32'h0000_9000, 1'b0, 13'd1024, 4'd10, 2'd0);
        wait_drain();
        err_addr = 32'hFFFF_FFFC;
        // R9: segments freed, later requests complete normally
        for (int i = 0; i < 5; i++) begin
            send(32'h0000_A000 + 32'h20 * i, 1'b0, 13'd8, 4'(11 + i), 2'd0);
        end
        wait_drain();

        chk(ei_rd == ei_n, "R6 bus read count", ei_rd, ei_n);
        chk(ec_rd == ec_n, "R8 completion count", ec_rd, ec_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule